// File: doc/BRIEF.md
# Cache Line Refill Sequencer with Priority Word Return

After a cache miss, this block fetches a whole 8-word line from the next memory level. It writes each arriving word into a line buffer, and it returns the word the processor asked for as soon as that word shows up. The processor therefore restarts without waiting for the rest of the line. The line fill then carries on in the background until all eight words are written.

A per-miss mode bit selects the fetch order.

- **Wrapped mode:** the memory burst starts at the missed word and wraps around the end of the line.
- **Linear mode:** the burst starts at word 0 and runs in ascending order.

In both modes the missed word goes to the processor in the cycle after it arrives. The memory response stream may pause for any number of cycles between words. A completion pulse marks the end of the fill, and the controller accepts the next miss from that cycle on.

Top module: `refill_ctrl`

## Requirements
- R1: After reset the block is idle. `miss_ready_o` is 1, and `mem_req_valid_o`, `lb_we_o`, `cpu_valid_o` and `line_done_o` are all 0.
- R2: In the cycle after a miss is accepted, `mem_req_valid_o` rises and carries the miss line address. While `mem_req_ready_i` is low, the request holds with a stable line, start word and wrap flag. It drops in the cycle after a handshake.
- R3: In wrapped mode (`mode_linear_i`=0), the start word is the miss offset and `mem_req_wrap_o`=1. The k-th accepted response word (k=0..7) is written to line-buffer index (offset+k) mod 8.
- R4: In linear mode (`mode_linear_i`=1), the start word is 0 and `mem_req_wrap_o`=0. The k-th response word is written to index k.
- R5: `cpu_valid_o` pulses exactly once per miss. The pulse comes in the cycle after the response that carries the missed word, and `cpu_data_o` holds that word.
- R6: Each response beat accepted in the fill phase produces exactly one line-buffer write in the following cycle, carrying the response data. Cycles with `rsp_valid_i`=0 produce no write and no processor return.
- R7: `line_done_o` pulses one cycle after the eighth line-buffer write. `miss_ready_o` is 0 from the cycle after acceptance until that pulse, and 1 again in the pulse cycle.
- R8: A miss presented while the block is busy is ignored. It changes neither the write indices nor the returned word.
- R9: Response beats that arrive before the memory request is accepted cause no line-buffer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid_i | input | 1 | Miss request present |
| miss_line_i | input | LINE_W | Line address of the miss |
| miss_off_i | input | OFF_W | Word offset of the missed word |
| mode_linear_i | input | 1 | 1 = linear order from word 0, 0 = wrapped order from the missed word |
| miss_ready_o | output | 1 | Block idle and able to take a miss |
| mem_req_valid_o | output | 1 | Burst request to memory |
| mem_req_ready_i | input | 1 | Memory accepts the burst request |
| mem_req_line_o | output | LINE_W | Line address of the burst |
| mem_req_word_o | output | OFF_W | First word of the burst |
| mem_req_wrap_o | output | 1 | Burst wraps at the line end |
| rsp_valid_i | input | 1 | Response word present |
| rsp_data_i | input | DATA_W | Response word |
| lb_we_o | output | 1 | Line-buffer write enable |
| lb_idx_o | output | OFF_W | Line-buffer word index |
| lb_data_o | output | DATA_W | Line-buffer write data |
| cpu_valid_o | output | 1 | Missed-word return strobe |
| cpu_data_o | output | DATA_W | Missed word |
| line_done_o | output | 1 | Line fill complete |

## Verification
In linear mode with offset 7, the missed word is also the last word of the line. The processor return strobe then falls in the same cycle as the final line-buffer write, and the completion pulse follows one cycle later. The bench sweeps every offset in both modes, so it reaches this coincidence and also the wrapped-mode case where the return coincides with the first write. In each case it checks that the strobe appears exactly once, at the index computed arithmetically, and that the completion pulse does not move.

// File: rtl/refill_pkg.sv
package refill_pkg;

    typedef enum logic [1:0] {
        RF_IDLE  = 2'd0,
        RF_REQ   = 2'd1,
        RF_FILL  = 2'd2,
        RF_DRAIN = 2'd3
    } rf_state_e;

endpackage

// File: rtl/refill_idx_gen.sv
module refill_idx_gen #(
    parameter int WORDS = 8,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [OFF_W-1:0] base_i,
    input  logic             step_i,
    output logic [OFF_W-1:0] idx_o,
    output logic             last_o
);

    localparam logic [OFF_W:0] WORDS_V = (OFF_W+1)'(WORDS);
    localparam logic [OFF_W-1:0] LAST_V = OFF_W'(WORDS - 1);

    typedef struct packed {
        logic [OFF_W-1:0] base;
        logic [OFF_W-1:0] cnt;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [OFF_W:0] sum;
    logic [OFF_W:0] wrapped;

    always_comb begin
        gen_d = gen_q;
        if (load_i) begin
            gen_d.base = base_i;
            gen_d.cnt  = '0;
        end else if (step_i) begin
            gen_d.cnt = (gen_q.cnt == LAST_V) ? '0 : gen_q.cnt + 1'b1;
        end
    end

    // modulo-WORDS add that also holds for a line length that is not a power of two
    always_comb begin
        sum     = {1'b0, gen_q.base} + {1'b0, gen_q.cnt};
        wrapped = (sum >= WORDS_V) ? sum - WORDS_V : sum;
    end

    assign idx_o  = wrapped[OFF_W-1:0];
    assign last_o = (gen_q.cnt == LAST_V);

    always_ff @(posedge clk) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

endmodule

// File: rtl/refill_fwd.sv
module refill_fwd #(
    parameter int OFF_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [OFF_W-1:0]  crit_i,
    input  logic              beat_i,
    input  logic [OFF_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              cpu_valid_o,
    output logic [DATA_W-1:0] cpu_data_o
);

    typedef struct packed {
        logic [OFF_W-1:0]  crit;
        logic              sent;
        logic              valid;
        logic [DATA_W-1:0] data;
    } fwd_t;

    fwd_t fwd_d, fwd_q;

    always_comb begin
        fwd_d       = fwd_q;
        fwd_d.valid = 1'b0;
        if (arm_i) begin
            fwd_d.crit = crit_i;
            fwd_d.sent = 1'b0;
        end else if (beat_i && !fwd_q.sent && (idx_i == fwd_q.crit)) begin
            fwd_d.valid = 1'b1;
            fwd_d.data  = data_i;
            fwd_d.sent  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fwd_q <= '0;
        else        fwd_q <= fwd_d;
    end

    assign cpu_valid_o = fwd_q.valid;
    assign cpu_data_o  = fwd_q.data;

    // R5: the return strobe is a single-cycle pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid_o |=> !cpu_valid_o);

    // R5: the returned word is the one that arrived on the matching beat
    a_r5_data_from_beat: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid_o |-> (cpu_data_o == $past(data_i)) && $past(beat_i));

endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
    import refill_pkg::*;
#(
    parameter int LINE_W = 26,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid_i,
    input  logic [LINE_W-1:0] miss_line_i,
    input  logic [OFF_W-1:0]  miss_off_i,
    input  logic              mode_linear_i,
    output logic              miss_ready_o,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [LINE_W-1:0] mem_req_line_o,
    output logic [OFF_W-1:0]  mem_req_word_o,
    output logic              mem_req_wrap_o,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic              lb_we_o,
    output logic [OFF_W-1:0]  lb_idx_o,
    output logic [DATA_W-1:0] lb_data_o,
    output logic              cpu_valid_o,
    output logic [DATA_W-1:0] cpu_data_o,
    output logic              line_done_o
);

    typedef struct packed {
        rf_state_e         st;
        logic [LINE_W-1:0] line;
        logic [OFF_W-1:0]  off;
        logic              linear;
        logic              lb_we;
        logic [OFF_W-1:0]  lb_idx;
        logic [DATA_W-1:0] lb_data;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             accept;
    logic             beat;
    logic [OFF_W-1:0] start_word;
    logic [OFF_W-1:0] cur_idx;
    logic             cur_last;

    assign accept     = (ctl_q.st == RF_IDLE) && miss_valid_i;
    assign beat       = (ctl_q.st == RF_FILL) && rsp_valid_i;
    assign start_word = mode_linear_i ? '0 : miss_off_i;

    refill_idx_gen #(
        .WORDS (WORDS)
    ) u_idx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .base_i (start_word),
        .step_i (beat),
        .idx_o  (cur_idx),
        .last_o (cur_last)
    );

    refill_fwd #(
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_fwd (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (accept),
        .crit_i      (miss_off_i),
        .beat_i      (beat),
        .idx_i       (cur_idx),
        .data_i      (rsp_data_i),
        .cpu_valid_o (cpu_valid_o),
        .cpu_data_o  (cpu_data_o)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.lb_we = 1'b0;
        ctl_d.done  = 1'b0;
        unique case (ctl_q.st)
            RF_IDLE: begin
                if (miss_valid_i) begin
                    ctl_d.st     = RF_REQ;
                    ctl_d.line   = miss_line_i;
                    ctl_d.off    = miss_off_i;
                    ctl_d.linear = mode_linear_i;
                end
            end
            RF_REQ: begin
                if (mem_req_ready_i) ctl_d.st = RF_FILL;
            end
            RF_FILL: begin
                if (rsp_valid_i) begin
                    ctl_d.lb_we   = 1'b1;
                    ctl_d.lb_idx  = cur_idx;
                    ctl_d.lb_data = rsp_data_i;
                    if (cur_last) ctl_d.st = RF_DRAIN;
                end
            end
            RF_DRAIN: begin
                ctl_d.st   = RF_IDLE;
                ctl_d.done = 1'b1;
            end
            default: ctl_d.st = RF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= RF_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign miss_ready_o    = (ctl_q.st == RF_IDLE);
    assign mem_req_valid_o = (ctl_q.st == RF_REQ);
    assign mem_req_line_o  = ctl_q.line;
    assign mem_req_word_o  = ctl_q.linear ? '0 : ctl_q.off;
    assign mem_req_wrap_o  = !ctl_q.linear;
    assign lb_we_o         = ctl_q.lb_we;
    assign lb_idx_o        = ctl_q.lb_idx;
    assign lb_data_o       = ctl_q.lb_data;
    assign line_done_o     = ctl_q.done;

    // R2: an unaccepted request holds its contents
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=>
            mem_req_valid_o && $stable(mem_req_word_o) && $stable(mem_req_line_o));

    // R2: request drops after the handshake
    a_r2_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && mem_req_ready_i |=> !mem_req_valid_o);

    // R6: every line-buffer write traces back to a response beat
    a_r6_write_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
        lb_we_o |-> $past(rsp_valid_i) && (lb_data_o == $past(rsp_data_i)));

    // R7: completion directly follows a line-buffer write and reopens the input
    a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        line_done_o |-> $past(lb_we_o) && miss_ready_o && !lb_we_o);

    // R8: a busy block stays busy while no completion is signalled
    a_r8_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_ready_o && !mem_req_valid_o && !lb_we_o |=> !miss_ready_o);

    // R9: no write while the request is still outstanding
    a_r9_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> !lb_we_o);

endmodule

// File: tb/refill_ctrl_bench.sv
module refill_ctrl_bench;

    localparam int LINE_W = 26;
    localparam int WORDS  = 8;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              miss_valid_i;
    logic [LINE_W-1:0] miss_line_i;
    logic [OFF_W-1:0]  miss_off_i;
    logic              mode_linear_i;
    logic              miss_ready_o;
    logic              mem_req_valid_o;
    logic              mem_req_ready_i;
    logic [LINE_W-1:0] mem_req_line_o;
    logic [OFF_W-1:0]  mem_req_word_o;
    logic              mem_req_wrap_o;
    logic              rsp_valid_i;
    logic [DATA_W-1:0] rsp_data_i;
    logic              lb_we_o;
    logic [OFF_W-1:0]  lb_idx_o;
    logic [DATA_W-1:0] lb_data_o;
    logic              cpu_valid_o;
    logic [DATA_W-1:0] cpu_data_o;
    logic              line_done_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    refill_ctrl #(.LINE_W(LINE_W), .WORDS(WORDS), .DATA_W(DATA_W)) u_refill_ctrl (
        .clk(clk), .rst_n(rst_n),
        .miss_valid_i(miss_valid_i), .miss_line_i(miss_line_i), .miss_off_i(miss_off_i),
        .mode_linear_i(mode_linear_i), .miss_ready_o(miss_ready_o),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_req_line_o(mem_req_line_o), .mem_req_word_o(mem_req_word_o),
        .mem_req_wrap_o(mem_req_wrap_o),
        .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
        .lb_we_o(lb_we_o), .lb_idx_o(lb_idx_o), .lb_data_o(lb_data_o),
        .cpu_valid_o(cpu_valid_o), .cpu_data_o(cpu_data_o), .line_done_o(line_done_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word_val(input int line, input int w);
        return 32'hC0DE_0000 ^ (32'(line) << 8) ^ 32'(w);
    endfunction

    task automatic run_miss(input int mode, input int off);
        int line;
        int cpu_seen;
        line = 100 + mode * 8 + off;
        cpu_seen = 0;
        @(negedge clk);
        chk("R7 ready before miss", 32'(miss_ready_o), 1);
        miss_valid_i  = 1'b1;
        miss_line_i   = LINE_W'(line);
        miss_off_i    = OFF_W'(off);
        mode_linear_i = mode[0];
        @(negedge clk);
        miss_valid_i = 1'b0;
        chk("R7 busy after accept", 32'(miss_ready_o), 0);
        chk("R2 request raised", 32'(mem_req_valid_o), 1);
        chk("R2 request line", 32'(mem_req_line_o), 32'(line));
        chk(mode ? "R4 start word" : "R3 start word", 32'(mem_req_word_o), mode ? 0 : 32'(off));
        chk(mode ? "R4 wrap flag" : "R3 wrap flag", 32'(mem_req_wrap_o), mode ? 0 : 1);
        // stall the request; stray response beats meanwhile (R9)
        for (int s = 0; s < off % 3; s++) begin
            rsp_valid_i = 1'b1;
            rsp_data_i  = 32'hDEAD_BEEF;
            @(negedge clk);
            chk("R2 request held", 32'(mem_req_valid_o), 1);
            chk("R2 start word stable", 32'(mem_req_word_o), mode ? 0 : 32'(off));
            if (s > 0) chk("R9 stray beat ignored", 32'(lb_we_o), 0);
        end
        rsp_valid_i     = 1'b0;
        mem_req_ready_i = 1'b1;
        @(negedge clk);
        mem_req_ready_i = 1'b0;
        chk("R2 request dropped", 32'(mem_req_valid_o), 0);
        chk("R9 no write before fill", 32'(lb_we_o), 0);
        for (int k = 0; k < WORDS; k++) begin
            int w;
            w = mode ? k : (off + k) % WORDS;
            if ((k + off + mode) % 3 == 0) begin
                rsp_valid_i = 1'b0;
                if (k == 3) begin
                    miss_valid_i = 1'b1;
                    miss_off_i   = OFF_W'(off ^ 1);
                    mode_linear_i = ~mode[0];
                end
                @(negedge clk);
                miss_valid_i = 1'b0;
                chk("R6 idle gap no write", 32'(lb_we_o), 0);
                chk("R6 idle gap no return", 32'(cpu_valid_o), 0);
                chk("R8 busy during fill", 32'(miss_ready_o), 0);
            end
            rsp_valid_i = 1'b1;
            rsp_data_i  = word_val(line, w);
            @(negedge clk);
            rsp_valid_i = 1'b0;
            chk("R6 write per beat", 32'(lb_we_o), 1);
            chk(mode ? "R4 write index" : "R3 write index", 32'(lb_idx_o), 32'(w));
            chk("R6 write data", lb_data_o, word_val(line, w));
            chk("R5 return timing", 32'(cpu_valid_o), (w == off) ? 1 : 0);
            if (cpu_valid_o) begin
                cpu_seen++;
                chk("R5 return data", cpu_data_o, word_val(line, off));
            end
            chk("R7 no early done", 32'(line_done_o), 0);
            chk("R7 busy until done", 32'(miss_ready_o), 0);
        end
        @(negedge clk);
        chk("R7 done pulse", 32'(line_done_o), 1);
        chk("R7 ready with done", 32'(miss_ready_o), 1);
        chk("R7 no write with done", 32'(lb_we_o), 0);
        chk("R5 no late return", 32'(cpu_valid_o), 0);
        chk("R5 exactly one return", 32'(cpu_seen), 1);
    endtask

    initial begin
        rst_n           = 1'b0;
        miss_valid_i    = 1'b0;
        miss_line_i     = '0;
        miss_off_i      = '0;
        mode_linear_i   = 1'b0;
        mem_req_ready_i = 1'b0;
        rsp_valid_i     = 1'b0;
        rsp_data_i      = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", 32'(miss_ready_o), 1);
        chk("R1 no request", 32'(mem_req_valid_o), 0);
        chk("R1 no write", 32'(lb_we_o), 0);
        chk("R1 no return", 32'(cpu_valid_o), 0);
        chk("R1 no done", 32'(line_done_o), 0);
        for (int mode = 0; mode < 2; mode++)
            for (int off = 0; off < WORDS; off++)
                run_miss(mode, off);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule